// File: doc/BRIEF.md
# Broadcast Fan-Out Queue

The block accepts a stream of words from a single producer and hands a copy of every word to each of a fixed set of consumers. Incoming words land in a small queue. The word at the head of that queue goes out on one shared data bus, and each consumer has its own valid and acknowledge pair. A private "taken" bit for each consumer records whether that consumer has already accepted the current word. A consumer that has taken its copy stops seeing valid, while the others can still take theirs at their own pace. One slow consumer therefore never forces a fast one to repeat a word or to wait for it.

The head entry leaves the queue only when every taken bit is set. In that cycle all taken bits clear and the queue advances. The next word is offered to every consumer from the following cycle. The number of consumers, the queue depth and the word width are elaboration-time parameters.

Top module: `bcast_sender`

## Requirements
- R1: While `rst` is high and in the first cycle after it, every bit of `out_valid` is 0 and `in_ready` is 1.
- R2: `out_valid[i]` is 1 exactly when the queue holds at least one word and consumer i has not yet taken the head word.
- R3: An acknowledge on `out_ack[i]` in a cycle where `out_valid[i]` is 1 marks the head as taken by consumer i, and `out_valid[i]` is 0 from the next cycle.
- R4: An acknowledge from a consumer whose `out_valid[i]` is 0 has no effect. This covers a consumer that already took the head and a queue that is empty.
- R5: In the cycle after the last consumer takes the head, all of `out_valid` is 0. The head then retires and all taken bits clear on that same edge. If another word is queued, it is offered to every consumer (all `out_valid` bits 1) in the cycle after that.
- R6: `out_data` carries the head word. Words leave in the order they were accepted, and the data stays stable for as long as any consumer is still offered it.
- R7: A word is accepted when `in_valid` and `in_ready` are both 1. `in_ready` is 0 exactly when the queue holds DEPTH words.
- R8: Over any run, each consumer accepts every word the producer pushed exactly once and in push order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | DATA_W | Word from the producer |
| in_valid | input | 1 | Producer has a word |
| in_ready | output | 1 | Queue can take a word this cycle |
| out_data | output | DATA_W | Head word, shared by all consumers |
| out_valid | output | N_CONS | Per-consumer offer of the head word |
| out_ack | input | N_CONS | Per-consumer acceptance of the offered word |

## Verification
A directed prologue sends acknowledges into an empty queue and repeats an acknowledge from a consumer that has already taken the head. These tell a design that honours only offered acknowledges apart from one that latches them blindly. It then lets consumers finish a word one at a time, which exposes any retire that comes early or late. Randomised phases follow with different stall probabilities for each consumer: balanced, one consumer badly lagging, and all consumers eager under a producer that keeps the queue full. These separate per-consumer tracking from lock-step delivery and show how back-pressure behaves at full depth. A behavioural queue model is compared against the outputs on every cycle, and each consumer's received stream is compared with the pushed stream at the end.

// File: rtl/bcast_pkg.sv
package bcast_pkg;
  // width of an index into a structure of n entries (at least one bit)
  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // width of a counter that must reach the value n
  function automatic int unsigned cnt_width(input int unsigned n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/bcast_queue.sv
module bcast_queue #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head_data,
  output logic              not_empty,
  output logic              full
);
  localparam int PW = bcast_pkg::idx_width(DEPTH);
  localparam int CW = bcast_pkg::cnt_width(DEPTH);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [DATA_W-1:0] store [DEPTH];
  logic [PW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     fill;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  // storage carries no reset so it can map onto RAM
  always_ff @(posedge clk) begin
    if (push) store[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      unique case ({push, pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  assign head_data = store[rd_ptr];
  assign not_empty = (fill != '0);
  assign full      = (fill == CW'(DEPTH));
endmodule

// File: rtl/bcast_taken.sv
module bcast_taken #(
  parameter int N_CONS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              head_valid,
  input  logic [N_CONS-1:0] ack,
  output logic [N_CONS-1:0] offer,
  output logic              all_taken
);
  logic [N_CONS-1:0] taken;

  for (genvar i = 0; i < N_CONS; i++) begin : g_cons
    assign offer[i] = head_valid & ~taken[i];

    always_ff @(posedge clk) begin
      if (rst)                   taken[i] <= 1'b0;
      else if (all_taken)        taken[i] <= 1'b0;
      else if (offer[i] & ack[i]) taken[i] <= 1'b1;
    end
  end

  assign all_taken = &taken;
endmodule

// File: rtl/bcast_sender.sv
module bcast_sender #(
  parameter int DATA_W = 8,
  parameter int N_CONS = 4,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [N_CONS-1:0] out_valid,
  input  logic [N_CONS-1:0] out_ack
);
  logic q_full, q_not_empty, retire, accept;

  assign in_ready = ~q_full;
  assign accept   = in_valid & ~q_full;

  bcast_queue #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_queue (
    .clk       (clk),
    .rst       (rst),
    .push      (accept),
    .push_data (in_data),
    .pop       (retire),
    .head_data (out_data),
    .not_empty (q_not_empty),
    .full      (q_full)
  );

  bcast_taken #(.N_CONS(N_CONS)) i_taken (
    .clk        (clk),
    .rst        (rst),
    .head_valid (q_not_empty),
    .ack        (out_ack),
    .offer      (out_valid),
    .all_taken  (retire)
  );
endmodule

// File: rtl/bcast_sender_chk.sv
module bcast_sender_chk #(
  parameter int DATA_W = 8,
  parameter int N_CONS = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              in_ready,
  input logic [DATA_W-1:0] out_data,
  input logic [N_CONS-1:0] out_valid,
  input logic [N_CONS-1:0] out_ack,
  input logic              q_not_empty
);
  // R1: one cycle after reset nothing is offered and the queue accepts
  assert_idle_after_reset_R1: assert property (@(posedge clk)
    rst |=> (out_valid == '0 && in_ready));

  // R3: an accepted offer is withdrawn on the next cycle
  for (genvar i = 0; i < N_CONS; i++) begin : g_ack
    assert_taken_drops_R3: assert property (@(posedge clk) disable iff (rst)
      (out_valid[i] && out_ack[i]) |=> !out_valid[i]);
  end

  // R4: acknowledges into an empty queue leave no trace on the next word
  assert_empty_ack_ignored_R4: assert property (@(posedge clk) disable iff (rst)
    !q_not_empty |=> (out_valid == '0 || &out_valid));

  // R5: after the all-taken cycle a fresh head goes to every consumer
  assert_retire_reoffers_R5: assert property (@(posedge clk) disable iff (rst)
    (q_not_empty && out_valid == '0) |=> (out_valid == '0 || &out_valid));

  // R6: head word holds while anyone is still offered it
  assert_head_stable_R6: assert property (@(posedge clk) disable iff (rst)
    (|out_valid) |=> $stable(out_data));

  // R7: back-pressure only with a non-empty queue
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    !in_ready |-> q_not_empty);
endmodule

bind bcast_sender bcast_sender_chk #(.DATA_W(DATA_W), .N_CONS(N_CONS)) i_chk (
  .clk         (clk),
  .rst         (rst),
  .in_ready    (in_ready),
  .out_data    (out_data),
  .out_valid   (out_valid),
  .out_ack     (out_ack),
  .q_not_empty (q_not_empty)
);

// File: tb/test_bcast_sender.sv
module test_bcast_sender;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 8;
  localparam int N_CONS = 4;
  localparam int DEPTH  = 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [DATA_W-1:0] in_data = '0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [DATA_W-1:0] out_data;
  logic [N_CONS-1:0] out_valid;
  logic [N_CONS-1:0] out_ack = '0;

  int vectors = 0;
  int errors  = 0;

  logic [DATA_W-1:0] sent_q[$];
  logic [DATA_W-1:0] got_q[N_CONS][$];
  logic [DATA_W-1:0] mq[$];
  logic [N_CONS-1:0] mflag;
  logic              m_ret;
  int                m_sz;
  logic [DATA_W-1:0] next_word = 8'h10;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcast_sender #(.DATA_W(DATA_W), .N_CONS(N_CONS), .DEPTH(DEPTH)) i_bcast_sender (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .out_data(out_data), .out_valid(out_valid), .out_ack(out_ack)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: a queue plus one taken bit per consumer
  always @(posedge clk) begin
    if (rst) begin
      mq.delete();
      mflag = '0;
    end else begin
      m_sz  = mq.size();
      m_ret = (m_sz > 0) && (&mflag);
      if (m_ret) begin
        void'(mq.pop_front());
        mflag = '0;
      end else if (m_sz > 0) begin
        mflag = mflag | out_ack;
      end
      if (in_valid && m_sz < DEPTH) mq.push_back(in_data);
    end
  end

  // cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      check("R7", {31'b0, in_ready}, {31'b0, mq.size() < DEPTH});
      for (int i = 0; i < N_CONS; i++)
        check("R2", {31'b0, out_valid[i]}, {31'b0, (mq.size() > 0) && !mflag[i]});
      if (mq.size() > 0) check("R6", {24'b0, out_data}, {24'b0, mq[0]});
    end
  end

  // drive one cycle of stimulus and log what each side takes
  task automatic step(input logic v, input logic [DATA_W-1:0] d, input logic [N_CONS-1:0] a);
    @(negedge clk);
    #1;
    in_valid = v;
    in_data  = d;
    out_ack  = a;
    if (!rst) begin
      if (v && in_ready) sent_q.push_back(d);
      for (int i = 0; i < N_CONS; i++)
        if (a[i] && out_valid[i]) got_q[i].push_back(out_data);
    end
  endtask

  task automatic random_phase(input int cycles, input int push_pct, input int slow_pct, input int fast_pct);
    for (int c = 0; c < cycles; c++) begin
      logic [N_CONS-1:0] a;
      logic v;
      for (int i = 0; i < N_CONS; i++)
        a[i] = ($urandom_range(99) < ((i == 0) ? slow_pct : fast_pct));
      v = ($urandom_range(99) < push_pct);
      step(v, next_word, a);
      if (v && in_ready) next_word = next_word + 1'b1;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    step(1'b0, '0, '0);
    rst = 1'b0;
    step(1'b0, '0, '0);
    check("R1 valid", {28'b0, out_valid}, 32'h0);
    check("R1 ready", {31'b0, in_ready}, 32'h1);

    // acknowledges into an empty queue
    repeat (3) step(1'b0, '0, '1);
    step(1'b1, 8'hA1, '0);
    step(1'b0, '0, '0);
    check("R4 empty acks ignored", {28'b0, out_valid}, 32'hF);
    check("R6 head", {24'b0, out_data}, 32'hA1);

    // consumer 0 takes first, then repeats its ack
    step(1'b0, '0, 4'b0001);
    step(1'b1, 8'hB2, 4'b0001);
    check("R3 taken drops", {28'b0, out_valid}, 32'hE);
    step(1'b0, '0, 4'b1110);
    check("R4 repeat ack ignored", {28'b0, out_valid}, 32'hE);
    check("R6 head held", {24'b0, out_data}, 32'hA1);
    step(1'b0, '0, '0);
    check("R5 all taken idle", {28'b0, out_valid}, 32'h0);
    step(1'b0, '0, '0);
    check("R5 reoffer", {28'b0, out_valid}, 32'hF);
    check("R5 next head", {24'b0, out_data}, 32'hB2);
    step(1'b0, '0, '1);
    step(1'b0, '0, '0);
    check("R5 all taken idle", {28'b0, out_valid}, 32'h0);
    step(1'b0, '0, '0);
    check("R5 empty after retire", {28'b0, out_valid}, 32'h0);

    // fill to depth with no takers
    step(1'b1, 8'hC3, '0);
    step(1'b1, 8'hD4, '0);
    step(1'b1, 8'hE5, '0);
    check("R7 full", {31'b0, in_ready}, 32'h0);
    step(1'b0, '0, '0);
    check("R7 still full", {31'b0, in_ready}, 32'h0);

    random_phase(800, 60, 50, 50);
    random_phase(800, 80, 10, 90);
    random_phase(800, 100, 95, 95);
    random_phase(600, 50, 30, 70);
    repeat (60) step(1'b0, '0, '1);

    // R8: every consumer saw the pushed stream once, in order
    for (int i = 0; i < N_CONS; i++) begin
      check("R8 count", got_q[i].size(), sent_q.size());
      if (got_q[i].size() == sent_q.size())
        for (int k = 0; k < sent_q.size(); k++)
          if (got_q[i][k] !== sent_q[k]) check("R8 order", {24'b0, got_q[i][k]}, {24'b0, sent_q[k]});
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule